// File: doc/BRIEF.md
# Serial Configuration Loader with Latch Select

This block is the configuration front end of a frequency-synthesizer control core. An external host drives three wires: a serial clock, a serial data line and a load strobe. All three are sampled into the core's system clock domain. Each rising edge of the serial clock shifts one data bit into a 24-bit word, most significant bit first. When the load strobe rises, the word is copied whole into one of four 24-bit configuration latches. The two bits shifted in last, which sit in the word's two lowest positions, choose the latch.

Latch 0 also feeds two pieces of logic inside the block. One of its bits is a software power-down request. An external chip-enable pin qualifies that request, and the result is driven out as a power-down flag and as a charge-pump drive enable. A 3-bit field of latch 0 selects what the single monitor pin shows: constant low, the lock-detect signal, the divided RF signal or the divided reference signal. All four latches clear on reset, so the monitor pin starts low.

Top module: `ser_cfg_loader`

## Requirements
- R1: After reset all four latches read zero, the monitor output is low and, with chip enable high, the power-down flag is low.
- R2: On each rising edge of the serial clock, taken while load is low, the word shifts left by one and the sampled data bit enters bit 0. After 24 such edges the first bit sent sits in bit 23.
- R3: On a rising edge of load, the whole 24-bit word, including its two select bits, is written into the latch whose index equals word bits [1:0]. Code 0 selects latch 0, 1 selects latch 1, 2 selects latch 2 and 3 selects latch 3.
- R4: A load leaves the three latches it does not select unchanged.
- R5: A load strobe held high writes exactly once. Its latch keeps its value for as long as load stays high.
- R6: Serial clock edges that arrive while load is high leave the word unchanged. A later load of the same word writes the same value.
- R7: While chip enable is low, the power-down flag is 1 and the charge-pump drive enable is 0, whatever latch 0 holds.
- R8: While chip enable is high, the power-down flag equals latch 0 bit 3, and the charge-pump drive enable is its inverse.
- R9: Latch 0 bits [6:4] select the monitor output: 0 gives constant low, 1 gives lock detect, 2 gives the divided RF input, 3 gives the divided reference input, and codes 4 to 7 give constant low.
- R10: The new latch value appears at the third rising system clock edge after load is first seen high, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| serLoad | input | 1 | Load strobe, asynchronous |
| chipEn | input | 1 | Chip enable, low forces power-down |
| lockDet | input | 1 | Lock-detect status for the monitor |
| rfScaled | input | 1 | Divided RF signal for the monitor |
| refScaled | input | 1 | Divided reference signal for the monitor |
| latchBus | output | 96 | Four latches, latch k at bits [24k+23:24k] |
| powerDown | output | 1 | Qualified power-down flag |
| cpDriveEn | output | 1 | Charge-pump drive enable |
| monitorOut | output | 1 | Selected monitor signal |

## Verification
A select decode that is off by one, or a load that fires more than once, writes a latch other than the one intended. The wrong value is on `latchBus` by the third system clock edge after load rises. If edge detection or gating on the serial clock is wrong, the shifted word is wrong. That shows up only at the next load, as a latch value that is rotated or holds extra bits. A bad field position in latch 0 shows up at once, on `monitorOut` or `powerDown`, as soon as that latch is written.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

  // Strobes from the control unit to the datapath, one system clock wide
  typedef struct packed {
    logic shiftEn;   // shift one bit into the word
    logic shiftBit;  // bit value to shift in
    logic loadEn;    // copy the word into the selected latch
    logic loadHigh;  // synchronised load level, freezes the word
  } ser_strobe_t;

  localparam int MON_W = 3;

  typedef enum logic [MON_W-1:0] {
    MON_LOW  = 3'd0,
    MON_LOCK = 3'd1,
    MON_RF   = 3'd2,
    MON_REF  = 3'd3
  } mon_sel_e;

endpackage

// File: rtl/ser_cfg_ctrl.sv
module ser_cfg_ctrl
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLoad,
  output ser_strobe_t strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] dataSync;
  logic [SYNC_STAGES-1:0] loadSync;
  logic                   clkPrev;
  logic                   loadPrev;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clkSync  <= '0;
          dataSync <= '0;
          loadSync <= '0;
        end else begin
          clkSync  <= {clkSync[SYNC_STAGES-2:0], serClk};
          dataSync <= {dataSync[SYNC_STAGES-2:0], serData};
          loadSync <= {loadSync[SYNC_STAGES-2:0], serLoad};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clkSync  <= '0;
          dataSync <= '0;
          loadSync <= '0;
        end else begin
          clkSync  <= serClk;
          dataSync <= serData;
          loadSync <= serLoad;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev  <= 1'b0;
      loadPrev <= 1'b0;
    end else begin
      clkPrev  <= clkSync[LAST];
      loadPrev <= loadSync[LAST];
    end
  end

  logic clkRise;
  logic loadRise;

  always_comb begin
    clkRise       = clkSync[LAST] & ~clkPrev;
    loadRise      = loadSync[LAST] & ~loadPrev;
    strb.loadHigh = loadSync[LAST];
    strb.loadEn   = loadRise;
    strb.shiftEn  = clkRise & ~loadSync[LAST];
    strb.shiftBit = dataSync[LAST];
  end

endmodule

// File: rtl/ser_cfg_dp.sv
module ser_cfg_dp
  import ser_cfg_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int SEL_W     = 2,
  parameter int PD_POS    = 3,
  parameter int MON_POS   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  ser_strobe_t                       strb,
  input  logic                              chipEn,
  input  logic                              lockDet,
  input  logic                              rfScaled,
  input  logic                              refScaled,
  output logic [WORD_W-1:0]                 srWord,
  output logic [(WORD_W<<SEL_W)-1:0]        latchBus,
  output logic                              powerDown,
  output logic                              cpDriveEn,
  output logic                              monitorOut
);

  localparam int NUM_LATCH = 1 << SEL_W;

  logic [WORD_W-1:0] latchArr [NUM_LATCH];
  logic [SEL_W-1:0]  destSel;

  // Shift register, MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srWord <= '0;
    end else if (strb.shiftEn) begin
      srWord <= {srWord[WORD_W-2:0], strb.shiftBit};
    end
  end

  assign destSel = srWord[SEL_W-1:0];

  // One latch per select code
  generate
    for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          latchArr[g] <= '0;
        end else if (strb.loadEn && (destSel == SEL_W'(g))) begin
          latchArr[g] <= srWord;
        end
      end
      assign latchBus[g*WORD_W +: WORD_W] = latchArr[g];
    end
  endgenerate

  // Power-down qualified by chip enable, taken from latch 0
  logic pdReq;
  assign pdReq     = latchArr[0][PD_POS];
  assign powerDown = ~chipEn | pdReq;
  assign cpDriveEn = chipEn & ~pdReq;

  // Monitor multiplexer, select field in latch 0
  mon_sel_e monSel;
  assign monSel = mon_sel_e'(latchArr[0][MON_POS +: MON_W]);

  always_comb begin
    case (monSel)
      MON_LOCK: monitorOut = lockDet;
      MON_RF:   monitorOut = rfScaled;
      MON_REF:  monitorOut = refScaled;
      default:  monitorOut = 1'b0;
    endcase
  end

endmodule

// File: rtl/ser_cfg_loader.sv
module ser_cfg_loader
  import ser_cfg_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PD_POS      = 3,
  parameter int MON_POS     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       serClk,
  input  logic                       serData,
  input  logic                       serLoad,
  input  logic                       chipEn,
  input  logic                       lockDet,
  input  logic                       rfScaled,
  input  logic                       refScaled,
  output logic [(WORD_W<<SEL_W)-1:0] latchBus,
  output logic                       powerDown,
  output logic                       cpDriveEn,
  output logic                       monitorOut
);

  ser_strobe_t       strb;
  logic [WORD_W-1:0] srWord;

  ser_cfg_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .serClk (serClk),
    .serData(serData),
    .serLoad(serLoad),
    .strb   (strb)
  );

  ser_cfg_dp #(
    .WORD_W (WORD_W),
    .SEL_W  (SEL_W),
    .PD_POS (PD_POS),
    .MON_POS(MON_POS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .chipEn    (chipEn),
    .lockDet   (lockDet),
    .rfScaled  (rfScaled),
    .refScaled (refScaled),
    .srWord    (srWord),
    .latchBus  (latchBus),
    .powerDown (powerDown),
    .cpDriveEn (cpDriveEn),
    .monitorOut(monitorOut)
  );

endmodule

// File: rtl/ser_cfg_loader_chk.sv
module ser_cfg_loader_chk
  import ser_cfg_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int SEL_W   = 2,
  parameter int MON_POS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input ser_strobe_t                strb,
  input logic [WORD_W-1:0]          srWord,
  input logic [(WORD_W<<SEL_W)-1:0] latchBus,
  input logic                       chipEn,
  input logic                       powerDown,
  input logic                       cpDriveEn,
  input logic                       monitorOut
);

  localparam int NUM_LATCH = 1 << SEL_W;

  generate
    for (genvar g = 0; g < NUM_LATCH; g++) begin : g_chk
      // R3: selected latch takes the word
      a_r3_load_target: assert property (@(posedge clk) disable iff (!rst_n)
        (strb.loadEn && srWord[SEL_W-1:0] == SEL_W'(g))
          |=> latchBus[g*WORD_W +: WORD_W] == $past(srWord));
      // R4: unselected latch holds
      a_r4_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb.loadEn && srWord[SEL_W-1:0] == SEL_W'(g))
          |=> $stable(latchBus[g*WORD_W +: WORD_W]));
    end
  endgenerate

  // R5: one write strobe per load assertion
  a_r5_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadEn |=> !strb.loadEn);

  // R6: word frozen while load is high
  a_r6_frozen_word: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadHigh |=> $stable(srWord));

  // R7: chip enable low forces power-down
  a_r7_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
    !chipEn |-> (powerDown && !cpDriveEn));

  // R8: drive enable and power-down are complementary
  a_r8_complement: assert property (@(posedge clk) disable iff (!rst_n)
    cpDriveEn != powerDown);

  // R9: codes 4..7 drive the monitor low
  a_r9_unused_low: assert property (@(posedge clk) disable iff (!rst_n)
    latchBus[MON_POS + MON_W - 1] |-> !monitorOut);

endmodule

bind ser_cfg_loader ser_cfg_loader_chk #(
  .WORD_W (WORD_W),
  .SEL_W  (SEL_W),
  .MON_POS(MON_POS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strb      (strb),
  .srWord    (srWord),
  .latchBus  (latchBus),
  .chipEn    (chipEn),
  .powerDown (powerDown),
  .cpDriveEn (cpDriveEn),
  .monitorOut(monitorOut)
);

// File: tb/ser_cfg_loader_tb.sv
module ser_cfg_loader_tb;

  localparam int W = 24;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic chipEn = 1'b1, lockDet = 1'b0, rfScaled = 1'b0, refScaled = 1'b0;
  logic [W*N-1:0] latchBus;
  logic powerDown, cpDriveEn, monitorOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;
  logic [W-1:0] expLatch [N];

  always #10 clk = ~clk;

  ser_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .serLoad(serLoad), .chipEn(chipEn), .lockDet(lockDet),
    .rfScaled(rfScaled), .refScaled(refScaled), .latchBus(latchBus),
    .powerDown(powerDown), .cpDriveEn(cpDriveEn), .monitorOut(monitorOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); serData = b;
    waitN(3); serClk = 1'b1;
    waitN(3); serClk = 1'b0;
    waitN(2);
  endtask

  task automatic shiftWord(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic loadWord(input logic [W-1:0] w);
    shiftWord(w);
    @(negedge clk); serLoad = 1'b1;
    waitN(6); serLoad = 1'b0;
    waitN(4);
    expLatch[w[1:0]] = w;
  endtask

  task automatic checkAll(input string req);
    for (int k = 0; k < N; k++)
      chk(req, 32'(latchBus[k*W +: W]), 32'(expLatch[k]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nTests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    for (int k = 0; k < N; k++) expLatch[k] = '0;
    waitN(3);
    rst_n = 1'b1;
    waitN(2);
    // R1: reset state
    checkAll("R1 latch reset");
    chk("R1 monitor low", 32'(monitorOut), 0);
    chk("R1 powerDown low", 32'(powerDown), 0);

    // R2 R3 R4: sweep over select codes and data patterns
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < N; c++) begin
        w = W'(((p * 4 + c + 1) * 32'h9E3779B1) >> 5);
        w[1:0] = 2'(c);
        loadWord(w);
        checkAll("R2 R3 R4 sweep");
      end
    end

    // R10: latency of the latch update
    w = 24'hA5C3F1;
    shiftWord(w);
    @(negedge clk); serLoad = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 not yet at edge 2", 32'(latchBus[1*W +: W]), 32'(expLatch[1]));
    @(posedge clk); @(negedge clk);
    chk("R10 written at edge 3", 32'(latchBus[1*W +: W]), 32'(w));
    expLatch[1] = w;
    // R5: held load, no second write, nothing else touched
    waitN(20);
    checkAll("R5 held load");
    // R6: serial clock edges while load is high are ignored
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    checkAll("R6 edges during load");
    serLoad = 1'b0; waitN(4);
    serLoad = 1'b1; waitN(6);
    serLoad = 1'b0; waitN(4);
    checkAll("R6 reload same word");

    // R9: monitor select sweep, latch 0 bits [6:4]
    for (int s = 0; s < 8; s++) begin
      w = '0; w[6:4] = 3'(s);
      loadWord(w);
      for (int v = 0; v < 8; v++) begin
        lockDet = v[0]; rfScaled = v[1]; refScaled = v[2];
        #1;
        chk("R9 monitor", 32'(monitorOut),
            (s == 1) ? 32'(v[0]) : (s == 2) ? 32'(v[1]) : (s == 3) ? 32'(v[2]) : 0);
      end
    end

    // R7 R8: power-down qualification, latch 0 bit 3
    for (int pd = 0; pd < 2; pd++) begin
      w = '0; w[3] = 1'(pd);
      loadWord(w);
      for (int ce = 0; ce < 2; ce++) begin
        chipEn = 1'(ce); #1;
        if (ce == 0) begin
          chk("R7 powerDown", 32'(powerDown), 1);
          chk("R7 cpDriveEn", 32'(cpDriveEn), 0);
        end else begin
          chk("R8 powerDown", 32'(powerDown), 32'(pd));
          chk("R8 cpDriveEn", 32'(cpDriveEn), 32'(1 - pd));
        end
      end
    end
    checkAll("R4 final state");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule